// File: doc/BRIEF.md
# Virtually Indexed, Physically Tagged Set-Associative Cache Lookup

This block is the lookup path of a 64 KB, 16-way data cache that sits beside an address translation buffer. A request carries a 24-bit virtual address. Only the untranslated low 12 bits (the page offset) choose the set and the word inside the line. The translation buffer returns the physical page number in the same cycle as the request, so the tag and data arrays are read while translation is still running. One registered cycle later, the stored physical page numbers of all 16 ways are compared against the translated page number. The block then reports a hit with the selected 32-bit word, a miss, or a failed translation.

Each way holds exactly one 4 KB page worth of lines: 64 sets of 64-byte lines. Any two virtual aliases of one physical word therefore share a set, and because the tags are physical, both aliases see the same line. Refills arrive on a separate port that delivers a whole line, its set and its physical page number. Victim choice follows a fixed priority. A way that already holds the same physical page is overwritten first. Failing that, the lowest-numbered empty way is used. Only when the set is full does a per-set round-robin pointer pick the way.

Top module: `vipt_cache`

## Requirements
- R1: The set is taken from address bits [11:6] and the 32-bit word within the line from bits [5:2]. Bits [23:12] and [1:0] of the virtual address have no effect on the response.
- R2: A request accepted in cycle t produces exactly one response in cycle t+1 (`rsp_valid` high). In a cycle after no request, `rsp_valid`, `rsp_hit`, `rsp_miss` and `rsp_xlt_miss` are all low.
- R3: With valid translation, if a valid way of the selected set holds a tag equal to `xlt_ppn`, the response has `rsp_hit`=1, `rsp_way` set to that way, and `rsp_data` equal to word k of that line, where word k is `fill_line[32k+31:32k]`.
- R4: With valid translation and no matching valid way, the response has `rsp_miss`=1, `rsp_way`=0 and `rsp_data`=0.
- R5: A request with `xlt_valid` low gives `rsp_xlt_miss`=1 with both `rsp_hit` and `rsp_miss` low, whatever the contents of the set.
- R6: Two requests with different virtual page numbers, the same page offset and the same translated page number return the same hit, way and data.
- R7: A fill whose page number already sits in a valid way of the target set overwrites that way. Later lookups return the new line, and the same way is reported.
- R8: Otherwise, a fill goes to the lowest-numbered invalid way of the set.
- R9: A fill into a full set with no matching tag replaces the way named by that set's round-robin pointer. The pointer is 0 after reset and advances by one after each such replacement, wrapping from 15 to 0. Each set has its own pointer.
- R10: A lookup issued in the same cycle as a fill to the same set sees the set as it was before that fill. A lookup issued in the next cycle sees the filled line.
- R11: While reset is low and after it, no response is valid and every way of every set is empty, so every lookup with valid translation misses until filled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Lookup request strobe |
| req_vaddr | input | 24 | Virtual address of the lookup |
| xlt_valid | input | 1 | Translation for this request succeeded |
| xlt_ppn | input | 12 | Translated physical page number |
| fill_valid | input | 1 | Refill strobe |
| fill_set | input | 6 | Set receiving the refill |
| fill_ppn | input | 12 | Physical page number stored as the tag |
| fill_line | input | 512 | Refill line, word k in bits [32k+31:32k] |
| rsp_valid | output | 1 | Response present |
| rsp_hit | output | 1 | Lookup hit |
| rsp_miss | output | 1 | Lookup missed with valid translation |
| rsp_xlt_miss | output | 1 | Translation was not valid |
| rsp_way | output | 4 | Way that hit, 0 otherwise |
| rsp_data | output | 32 | Selected word on a hit, 0 otherwise |

## Verification
Directed sequences first fill one set way by way. This separates lowest-empty-way placement from the round-robin replacement that takes over once the set is full. A second set is filled beyond capacity to show that the pointers are independent. Lookups that sweep the virtual page number and the low byte bits against one translated page distinguish physical tagging and page-offset indexing from any use of translated bits. Sweeping the word bits catches a wrong word select. Refills of a resident page, same-cycle fill and lookup, and requests with translation withheld each exercise a single ordering rule. A long random mix over a few crowded sets, a small page-number pool and idle gaps is compared every clock against a behavioural model.

// File: rtl/vipt_pkg.sv
// Package: shared defaults and the victim-choice reason type for the cache.
// Assumes: page size and line size are powers of two and the line fits
// within one page.
package vipt_pkg;
    localparam int DEF_VA_W       = 24;
    localparam int DEF_PA_W       = 24;
    localparam int DEF_PAGE_W     = 12;
    localparam int DEF_LINE_BYTES = 64;
    localparam int DEF_WAYS       = 16;
    localparam int DEF_WORD_W     = 32;

    typedef enum logic [1:0] {
        VIC_MATCH = 2'd0,
        VIC_FREE  = 2'd1,
        VIC_RR    = 2'd2
    } vic_reason_e;
endpackage

// File: rtl/vipt_tag_store.sv
// Module: per-way physical tag and valid storage.
// A registered read port serves lookups. A combinational peek port serves
// victim selection for fills. One write port installs a tag and marks the
// entry valid. Valid bits are cleared by reset; the tags themselves are not.
// Assumes: SETS == 2**SET_W.
module vipt_tag_store #(
    parameter int SETS  = 64,
    parameter int WAYS  = 16,
    parameter int SET_W = 6,
    parameter int WAY_W = 4,
    parameter int PPN_W = 12
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         rd_en,
    input  logic [SET_W-1:0]             rd_set,
    output logic [WAYS-1:0][PPN_W-1:0]   rd_tags,
    output logic [WAYS-1:0]              rd_vld,
    input  logic [SET_W-1:0]             pk_set,
    output logic [WAYS-1:0][PPN_W-1:0]   pk_tags,
    output logic [WAYS-1:0]              pk_vld,
    input  logic                         wr_en,
    input  logic [SET_W-1:0]             wr_set,
    input  logic [WAY_W-1:0]             wr_way,
    input  logic [PPN_W-1:0]             wr_tag
);
    for (genvar w = 0; w < WAYS; w++) begin : g_way
        logic [PPN_W-1:0] tag_mem [SETS];
        logic [SETS-1:0]  vld_q;
        logic [PPN_W-1:0] rtag_q;
        logic             rvld_q;
        logic             wr_here;

        assign wr_here = wr_en && (wr_way == WAY_W'(w));

        // Store the physical page number written into this way.
        always_ff @(posedge clk) begin
            if (wr_here) begin
                tag_mem[wr_set] <= wr_tag;
            end
        end

        // Track which sets of this way hold a line.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                vld_q <= '0;
            end else if (wr_here) begin
                vld_q[wr_set] <= 1'b1;
            end
        end

        // Register this way's tag and valid bit for the lookup compare.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                rvld_q <= 1'b0;
                rtag_q <= '0;
            end else if (rd_en) begin
                rvld_q <= vld_q[rd_set];
                rtag_q <= tag_mem[rd_set];
            end
        end

        assign rd_tags[w] = rtag_q;
        assign rd_vld[w]  = rvld_q;
        assign pk_tags[w] = tag_mem[pk_set];
        assign pk_vld[w]  = vld_q[pk_set];
    end
endmodule

// File: rtl/vipt_data_store.sv
// Module: per-way line storage with a registered word read.
// Each lookup reads the selected word of the indexed set from every way in
// parallel; the hit vector later picks one. A fill writes a whole line.
// Assumes: SETS == 2**SET_W and LINE_W == WORD_W * 2**WSEL_W.
module vipt_data_store #(
    parameter int SETS   = 64,
    parameter int WAYS   = 16,
    parameter int SET_W  = 6,
    parameter int WAY_W  = 4,
    parameter int LINE_W = 512,
    parameter int WORD_W = 32,
    parameter int WSEL_W = 4
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          rd_en,
    input  logic [SET_W-1:0]              rd_set,
    input  logic [WSEL_W-1:0]             rd_wsel,
    output logic [WAYS-1:0][WORD_W-1:0]   rd_words,
    input  logic                          wr_en,
    input  logic [SET_W-1:0]              wr_set,
    input  logic [WAY_W-1:0]              wr_way,
    input  logic [LINE_W-1:0]             wr_line
);
    for (genvar w = 0; w < WAYS; w++) begin : g_way
        logic [LINE_W-1:0] line_mem [SETS];
        logic [WORD_W-1:0] word_q;

        // Install a refill line into this way.
        always_ff @(posedge clk) begin
            if (wr_en && (wr_way == WAY_W'(w))) begin
                line_mem[wr_set] <= wr_line;
            end
        end

        // Register the requested word of this way for the output mux.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                word_q <= '0;
            end else if (rd_en) begin
                word_q <= line_mem[rd_set][rd_wsel*WORD_W +: WORD_W];
            end
        end

        assign rd_words[w] = word_q;
    end
endmodule

// File: rtl/vipt_victim_pick.sv
// Module: chooses the way a refill is written into.
// Priority: a way already holding the same page, then the lowest empty way,
// then the set's round-robin pointer. The pointer moves only when it was used.
// Assumes: WAYS <= 2**WAY_W; peek inputs describe fill_set in this cycle.
module vipt_victim_pick
    import vipt_pkg::*;
#(
    parameter int SETS  = 64,
    parameter int WAYS  = 16,
    parameter int SET_W = 6,
    parameter int WAY_W = 4,
    parameter int PPN_W = 12
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        fill_valid,
    input  logic [SET_W-1:0]            fill_set,
    input  logic [PPN_W-1:0]            fill_ppn,
    input  logic [WAYS-1:0][PPN_W-1:0]  pk_tags,
    input  logic [WAYS-1:0]             pk_vld,
    output logic [WAY_W-1:0]            victim_way,
    output vic_reason_e                 victim_why
);
    localparam logic [WAY_W-1:0] LAST_WAY = WAY_W'(WAYS - 1);

    logic [WAY_W-1:0] rr_q [SETS];
    logic [WAYS-1:0]  match_v;
    logic [WAYS-1:0]  free_v;

    // Lowest set bit of a way vector, as a way number.
    function automatic logic [WAY_W-1:0] lowest_way(input logic [WAYS-1:0] v);
        logic [WAY_W-1:0] r;
        r = '0;
        for (int i = WAYS - 1; i >= 0; i--) begin
            if (v[i]) r = WAY_W'(i);
        end
        return r;
    endfunction

    // Classify each way of the fill set: resident same page, or empty.
    always_comb begin
        for (int i = 0; i < WAYS; i++) begin
            match_v[i] = pk_vld[i] && (pk_tags[i] == fill_ppn);
            free_v[i]  = !pk_vld[i];
        end
    end

    // Apply the placement priority.
    always_comb begin
        if (|match_v) begin
            victim_why = VIC_MATCH;
            victim_way = lowest_way(match_v);
        end else if (|free_v) begin
            victim_why = VIC_FREE;
            victim_way = lowest_way(free_v);
        end else begin
            victim_why = VIC_RR;
            victim_way = rr_q[fill_set];
        end
    end

    // Advance the set's round-robin pointer after it chose a victim.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int s = 0; s < SETS; s++) begin
                rr_q[s] <= '0;
            end
        end else if (fill_valid && (victim_why == VIC_RR)) begin
            rr_q[fill_set] <= (rr_q[fill_set] == LAST_WAY) ? '0
                                                          : rr_q[fill_set] + 1'b1;
        end
    end
endmodule

// File: rtl/vipt_cache.sv
// Module: top of the virtually indexed, physically tagged lookup unit.
// The set and word come from page-offset bits only. The arrays are read in
// the request cycle while translation runs alongside. In the next cycle the
// registered tags are compared with the registered translated page number.
// Assumes: the translation arrives in the request cycle; refills deliver a
// whole line; LINE_BYTES <= 2**PAGE_W.
module vipt_cache
    import vipt_pkg::*;
#(
    parameter int VA_W       = DEF_VA_W,
    parameter int PA_W       = DEF_PA_W,
    parameter int PAGE_W     = DEF_PAGE_W,
    parameter int LINE_BYTES = DEF_LINE_BYTES,
    parameter int WAYS       = DEF_WAYS,
    parameter int WORD_W     = DEF_WORD_W
) (
    input  logic                                    clk,
    input  logic                                    rst_n,
    input  logic                                    req_valid,
    input  logic [VA_W-1:0]                         req_vaddr,
    input  logic                                    xlt_valid,
    input  logic [PA_W-PAGE_W-1:0]                  xlt_ppn,
    input  logic                                    fill_valid,
    input  logic [PAGE_W-$clog2(LINE_BYTES)-1:0]    fill_set,
    input  logic [PA_W-PAGE_W-1:0]                  fill_ppn,
    input  logic [LINE_BYTES*8-1:0]                 fill_line,
    output logic                                    rsp_valid,
    output logic                                    rsp_hit,
    output logic                                    rsp_miss,
    output logic                                    rsp_xlt_miss,
    output logic [$clog2(WAYS)-1:0]                 rsp_way,
    output logic [WORD_W-1:0]                       rsp_data
);
    localparam int OFF_W  = $clog2(LINE_BYTES);
    localparam int SET_W  = PAGE_W - OFF_W;
    localparam int SETS   = 1 << SET_W;
    localparam int PPN_W  = PA_W - PAGE_W;
    localparam int WAY_W  = $clog2(WAYS);
    localparam int LINE_W = LINE_BYTES * 8;
    localparam int WORDS  = LINE_W / WORD_W;
    localparam int WSEL_W = $clog2(WORDS);
    localparam int BYTE_W = OFF_W - WSEL_W;

    logic [SET_W-1:0]                req_set;
    logic [WSEL_W-1:0]               req_wsel;
    logic                            unused_addr_bits;
    logic [WAYS-1:0][PPN_W-1:0]      rd_tags;
    logic [WAYS-1:0]                 rd_vld;
    logic [WAYS-1:0][PPN_W-1:0]      pk_tags;
    logic [WAYS-1:0]                 pk_vld;
    logic [WAYS-1:0][WORD_W-1:0]     rd_words;
    logic [WAY_W-1:0]                victim_way;
    vic_reason_e                     victim_why;
    logic                            rv_q;
    logic                            xv_q;
    logic [PPN_W-1:0]                ppn_q;
    logic [WAYS-1:0]                 hit_v;
    logic                            any_hit;
    logic [WAY_W-1:0]                hit_way;
    logic [WORD_W-1:0]               hit_word;

    assign req_set  = req_vaddr[PAGE_W-1:OFF_W];
    assign req_wsel = req_vaddr[OFF_W-1:BYTE_W];
    assign unused_addr_bits = ^{req_vaddr[VA_W-1:PAGE_W], req_vaddr[BYTE_W-1:0]};

    vipt_tag_store #(
        .SETS(SETS), .WAYS(WAYS), .SET_W(SET_W), .WAY_W(WAY_W), .PPN_W(PPN_W)
    ) tags_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .rd_en   (req_valid),
        .rd_set  (req_set),
        .rd_tags (rd_tags),
        .rd_vld  (rd_vld),
        .pk_set  (fill_set),
        .pk_tags (pk_tags),
        .pk_vld  (pk_vld),
        .wr_en   (fill_valid),
        .wr_set  (fill_set),
        .wr_way  (victim_way),
        .wr_tag  (fill_ppn)
    );

    vipt_data_store #(
        .SETS(SETS), .WAYS(WAYS), .SET_W(SET_W), .WAY_W(WAY_W),
        .LINE_W(LINE_W), .WORD_W(WORD_W), .WSEL_W(WSEL_W)
    ) data_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .rd_en    (req_valid),
        .rd_set   (req_set),
        .rd_wsel  (req_wsel),
        .rd_words (rd_words),
        .wr_en    (fill_valid),
        .wr_set   (fill_set),
        .wr_way   (victim_way),
        .wr_line  (fill_line)
    );

    vipt_victim_pick #(
        .SETS(SETS), .WAYS(WAYS), .SET_W(SET_W), .WAY_W(WAY_W), .PPN_W(PPN_W)
    ) victim_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .fill_valid (fill_valid),
        .fill_set   (fill_set),
        .fill_ppn   (fill_ppn),
        .pk_tags    (pk_tags),
        .pk_vld     (pk_vld),
        .victim_way (victim_way),
        .victim_why (victim_why)
    );

    // Capture request presence and translation result beside the array read.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rv_q  <= 1'b0;
            xv_q  <= 1'b0;
            ppn_q <= '0;
        end else begin
            rv_q <= req_valid;
            if (req_valid) begin
                xv_q  <= xlt_valid;
                ppn_q <= xlt_ppn;
            end
        end
    end

    // Compare each way's physical tag with the translated page number.
    always_comb begin
        for (int i = 0; i < WAYS; i++) begin
            hit_v[i] = rd_vld[i] && (rd_tags[i] == ppn_q);
        end
    end

    // Encode the hitting way and AND-OR select its word.
    always_comb begin
        hit_way  = '0;
        hit_word = '0;
        for (int i = WAYS - 1; i >= 0; i--) begin
            if (hit_v[i]) hit_way = WAY_W'(i);
        end
        for (int i = 0; i < WAYS; i++) begin
            hit_word = hit_word | (rd_words[i] & {WORD_W{hit_v[i]}});
        end
    end

    assign any_hit = |hit_v;

    // Form the response flags and payload.
    always_comb begin
        rsp_valid    = rv_q;
        rsp_xlt_miss = rv_q && !xv_q;
        rsp_hit      = rv_q && xv_q && any_hit;
        rsp_miss     = rv_q && xv_q && !any_hit;
        rsp_way      = rsp_hit ? hit_way : '0;
        rsp_data     = rsp_hit ? hit_word : '0;
    end
endmodule

// File: rtl/vipt_cache_chk.sv
// Module: temporal checks on the cache ports, attached by bind.
// Assumes: the parameters passed in match the bound instance.
module vipt_cache_chk #(
    parameter int VA_W   = 24,
    parameter int PPN_W  = 12,
    parameter int SET_W  = 6,
    parameter int OFF_W  = 6,
    parameter int WAY_W  = 4,
    parameter int WORD_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic [VA_W-1:0]   req_vaddr,
    input logic              xlt_valid,
    input logic [PPN_W-1:0]  xlt_ppn,
    input logic              fill_valid,
    input logic [SET_W-1:0]  fill_set,
    input logic [PPN_W-1:0]  fill_ppn,
    input logic              rsp_valid,
    input logic              rsp_hit,
    input logic              rsp_miss,
    input logic              rsp_xlt_miss,
    input logic [WAY_W-1:0]  rsp_way,
    input logic [WORD_W-1:0] rsp_data
);
    logic [SET_W-1:0] chk_set;
    logic             unused_chk_bits;

    assign chk_set = req_vaddr[OFF_W+SET_W-1:OFF_W];
    assign unused_chk_bits = ^{req_vaddr[VA_W-1:OFF_W+SET_W], req_vaddr[OFF_W-1:0]};

    // R2
    rsp_follows_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_valid);

    // R2
    no_rsp_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !rsp_valid && !rsp_hit && !rsp_miss && !rsp_xlt_miss);

    // R3
    one_outcome_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> $countones({rsp_hit, rsp_miss, rsp_xlt_miss}) == 1);

    // R4
    miss_payload_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_miss |-> (rsp_data == '0) && (rsp_way == '0));

    // R5
    xlt_fail_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && !xlt_valid |=> rsp_xlt_miss && !rsp_hit && !rsp_miss);

    // R10
    fill_seen_next_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) && $past(fill_valid) && req_valid && xlt_valid &&
        (chk_set == $past(fill_set)) && (xlt_ppn == $past(fill_ppn))
        |=> rsp_hit);
endmodule

bind vipt_cache vipt_cache_chk #(
    .VA_W   (VA_W),
    .PPN_W  (PA_W - PAGE_W),
    .SET_W  (PAGE_W - $clog2(LINE_BYTES)),
    .OFF_W  ($clog2(LINE_BYTES)),
    .WAY_W  ($clog2(WAYS)),
    .WORD_W (WORD_W)
) chk_i (.*);

// File: tb/vipt_cache_tb_top.sv
`timescale 1ns/1ps
module vipt_cache_tb_top;
    localparam int SETS = 64;
    localparam int WAYS = 16;

    logic         clk = 1'b0;
    logic         rst_n;
    logic         req_valid;
    logic [23:0]  req_vaddr;
    logic         xlt_valid;
    logic [11:0]  xlt_ppn;
    logic         fill_valid;
    logic [5:0]   fill_set;
    logic [11:0]  fill_ppn;
    logic [511:0] fill_line;
    logic         rsp_valid, rsp_hit, rsp_miss, rsp_xlt_miss;
    logic [3:0]   rsp_way;
    logic [31:0]  rsp_data;

    int    total = 0;
    int    bad   = 0;
    bit    done  = 0;
    string phase = "R11";

    // behavioural reference state
    logic [11:0]  m_tag [SETS][WAYS];
    bit           m_vld [SETS][WAYS];
    logic [511:0] m_dat [SETS][WAYS];
    int           m_rr  [SETS];

    // expected response for the edge just taken
    bit          e_rv, e_hit, e_miss, e_x;
    int          e_way;
    logic [31:0] e_dat;

    always #10 clk = ~clk;

    vipt_cache dut_i (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_vaddr(req_vaddr),
        .xlt_valid(xlt_valid), .xlt_ppn(xlt_ppn),
        .fill_valid(fill_valid), .fill_set(fill_set),
        .fill_ppn(fill_ppn), .fill_line(fill_line),
        .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_miss(rsp_miss),
        .rsp_xlt_miss(rsp_xlt_miss), .rsp_way(rsp_way), .rsp_data(rsp_data)
    );

    function automatic logic [511:0] mk_line(int seed);
        logic [511:0] l;
        for (int k = 0; k < 16; k++) begin
            l[k*32 +: 32] = {seed[15:0] ^ 16'h5A3C, 8'(k * 17), seed[23:16] ^ 8'(k)};
        end
        return l;
    endfunction

    function automatic logic [23:0] mk_va(int vpn, int set, int wsel, int byt);
        return {vpn[11:0], set[5:0], wsel[3:0], byt[1:0]};
    endfunction

    task automatic idle_inputs();
        req_valid  = 0; req_vaddr = '0; xlt_valid = 0; xlt_ppn = '0;
        fill_valid = 0; fill_set  = '0; fill_ppn  = '0; fill_line = '0;
    endtask

    task automatic model_reset();
        for (int s = 0; s < SETS; s++) begin
            m_rr[s] = 0;
            for (int w = 0; w < WAYS; w++) m_vld[s][w] = 0;
        end
    endtask

    // Reference behaviour at a clock edge: respond from old state, then fill.
    task automatic model_edge();
        int s, wi, found, vic;
        e_rv = req_valid; e_hit = 0; e_miss = 0; e_x = 0; e_way = 0; e_dat = '0;
        if (req_valid) begin
            s  = int'(req_vaddr[11:6]);
            wi = int'(req_vaddr[5:2]);
            if (!xlt_valid) e_x = 1;
            else begin
                found = -1;
                for (int w = 0; w < WAYS; w++)
                    if (found < 0 && m_vld[s][w] && m_tag[s][w] == xlt_ppn) found = w;
                if (found >= 0) begin
                    e_hit = 1; e_way = found; e_dat = m_dat[s][found][wi*32 +: 32];
                end else e_miss = 1;
            end
        end
        if (fill_valid) begin
            s = int'(fill_set);
            vic = -1;
            for (int w = 0; w < WAYS; w++)
                if (vic < 0 && m_vld[s][w] && m_tag[s][w] == fill_ppn) vic = w;
            for (int w = 0; w < WAYS; w++)
                if (vic < 0 && !m_vld[s][w]) vic = w;
            if (vic < 0) begin
                vic = m_rr[s];
                m_rr[s] = (m_rr[s] + 1) % WAYS;
            end
            m_vld[s][vic] = 1; m_tag[s][vic] = fill_ppn; m_dat[s][vic] = fill_line;
        end
    endtask

    task automatic compare();
        logic [39:0] act, exp;
        act = {rsp_valid, rsp_hit, rsp_miss, rsp_xlt_miss, rsp_way, rsp_data};
        exp = {e_rv, e_hit, e_miss, e_x, 4'(e_way), e_dat};
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: {v,hit,miss,xmiss,way,data} actual=%h expected=%h at %0t",
                     phase, act, exp, $time);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        model_edge();
        @(negedge clk);
        compare();
        idle_inputs();
    endtask

    task automatic lookup(logic [23:0] va, int ppn, bit xv);
        req_valid = 1; req_vaddr = va; xlt_valid = xv; xlt_ppn = 12'(ppn);
        tick();
    endtask

    task automatic fill(int set, int ppn, int seed);
        fill_valid = 1; fill_set = 6'(set); fill_ppn = 12'(ppn); fill_line = mk_line(seed);
        tick();
    endtask

    initial begin
        idle_inputs();
        rst_n = 0;
        model_reset();
        // R11: no valid response while in reset
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            total++;
            if (rsp_valid !== 1'b0) begin
                bad++;
                $display("FAIL R11: rsp_valid in reset actual=%b expected=0", rsp_valid);
            end
        end
        rst_n = 1;
        tick();

        phase = "R11";
        lookup(mk_va(0, 0, 0, 0), 0, 1);
        lookup(mk_va(7, 5, 3, 0), 12'h100, 1);
        lookup(mk_va(12'hFFF, 63, 15, 3), 12'hFFF, 1);

        phase = "R8";
        for (int i = 0; i < 16; i++) begin
            fill(5, 12'h100 + i, 1000 + i);
            lookup(mk_va(i, 5, i, 0), 12'h100 + i, 1);
        end

        phase = "R3";
        for (int k = 0; k < 16; k++) lookup(mk_va(3, 5, k, 0), 12'h10A, 1);

        phase = "R1";
        for (int v = 0; v < 8; v++) lookup(mk_va(v * 517, 5, v, v), 12'h104, 1);
        lookup(mk_va(0, 6, 0, 0), 12'h104, 1);

        phase = "R9";
        fill(5, 12'h200, 2000);
        lookup(mk_va(1, 5, 2, 0), 12'h200, 1);
        lookup(mk_va(1, 5, 2, 0), 12'h100, 1);
        fill(5, 12'h201, 2001);
        lookup(mk_va(1, 5, 9, 0), 12'h201, 1);
        for (int i = 0; i < 17; i++) fill(6, 12'h300 + i, 3000 + i);
        lookup(mk_va(0, 6, 0, 0), 12'h310, 1);
        lookup(mk_va(0, 6, 0, 0), 12'h300, 1);
        for (int i = 0; i < 16; i++) fill(5, 12'h400 + i, 4000 + i);
        lookup(mk_va(0, 5, 4, 0), 12'h40E, 1);
        lookup(mk_va(0, 5, 4, 0), 12'h40F, 1);

        phase = "R7";
        fill(5, 12'h405, 5555);
        lookup(mk_va(0, 5, 6, 0), 12'h405, 1);
        fill(6, 12'h305, 6666);
        lookup(mk_va(0, 6, 1, 0), 12'h305, 1);

        phase = "R6";
        lookup(mk_va(12'h000, 6, 3, 0), 12'h305, 1);
        lookup(mk_va(12'hABC, 6, 3, 0), 12'h305, 1);
        lookup(mk_va(12'hFFF, 6, 3, 2), 12'h305, 1);

        phase = "R5";
        lookup(mk_va(0, 6, 3, 0), 12'h305, 0);
        lookup(mk_va(0, 9, 3, 0), 12'h999, 0);

        phase = "R10";
        fill(20, 12'h777, 7777);
        req_valid = 1; req_vaddr = mk_va(2, 20, 1, 0); xlt_valid = 1; xlt_ppn = 12'h778;
        fill_valid = 1; fill_set = 20; fill_ppn = 12'h778; fill_line = mk_line(7778);
        tick();
        lookup(mk_va(2, 20, 1, 0), 12'h778, 1);

        phase = "R2";
        for (int i = 0; i < 4000; i++) begin
            if ($urandom_range(99) < 70) begin
                req_valid = 1;
                req_vaddr = mk_va($urandom_range(4095), ($urandom_range(4) == 4) ? 63 : $urandom_range(3),
                                  $urandom_range(15), $urandom_range(3));
                xlt_valid = ($urandom_range(9) != 0);
                xlt_ppn   = 12'($urandom_range(23));
            end
            if ($urandom_range(99) < 30) begin
                fill_valid = 1;
                fill_set   = ($urandom_range(4) == 4) ? 6'd63 : 6'($urandom_range(3));
                fill_ppn   = 12'($urandom_range(23));
                fill_line  = mk_line(int'($urandom));
            end
            tick();
        end

        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog: run did not end actual=hung expected=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule